// File: doc/BRIEF.md
# Dual Potentiometer Wiper Register Bank

This block sits behind a serial-bus command decoder and holds the register state of two 7-bit digital potentiometer channels. Each channel has a live wiper register and an image of a stored power-up value. The bank also keeps five general-purpose stored bytes and one control register. The decoder presents one register access per cycle: an address, write data and a write strobe. It reads back through a combinational data port.

A control bit decides which copy addresses 0 and 1 reach: the live wiper or the stored-value image. Any write that must reach storage is handed to an external storage engine as a one-cycle request that carries the address and the data. The block then watches the engine's busy flag, and while that flag is high it refuses every write. A second control bit is combined with an active-low pin to produce the per-channel shutdown flags. The wiper codes are driven out unchanged, whatever the shutdown state.

Top module: `dual_wiper_regs`

## Requirements
- R1: After reset both wiper codes and both stored-value images are 0x40, the general-purpose bytes are 0x00, the control register reads 0x40 (copy select 0, shutdown-control 1), and no storage request is raised.
- R2: Address 0 is channel 0, address 1 is channel 1, addresses 2 to 6 are the general-purpose bytes, and address 8 is the control register. A write to address 7 or to addresses 9 to 15 changes nothing and raises no request, and these addresses read 0x00.
- R3: When copy select (control bit 7) is 0, a write to address 0 or 1 stores the 7-bit value in that channel's image and also loads it into that channel's wiper. A request carrying that address and value is high for exactly the cycle after the write.
- R4: When copy select is 1, a write to address 0 or 1 changes only the wiper, raises no request, and reads of that address return the wiper. When copy select is 0, reads return the image and leave the wiper unchanged.
- R5: A write to a general-purpose byte stores all 8 bits and raises a request carrying that address and byte.
- R6: A write strobe seen while the busy input is 1 is ignored at every address: no register changes and no request is raised.
- R7: In the control register only bit 7 (copy select) and bit 6 (shutdown-control) can be written. Bit 5 reads the busy input, and bits 4 to 0 read 0. Writes to it raise no request.
- R8: Both shutdown flags are 1 when shutdown-control is 0 or when the active-low shutdown pin is 0, and they are 0 otherwise.
- R9: Shutdown leaves the wiper codes unchanged, and all registers stay writable during shutdown. When shutdown ends, the wipers hold the values set before or during the shutdown.
- R10: Bit 7 of data written to a channel address is discarded, and reads of addresses 0 and 1 return bit 7 as 0. Code 0x00 is the wiper end nearest the low terminal and 0x7F the end nearest the high terminal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the current address |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Combinational read data for addr |
| nv_busy | input | 1 | Storage engine busy flag |
| nv_req | output | 1 | One-cycle storage write request |
| nv_addr | output | 4 | Address carried with nv_req |
| nv_data | output | 8 | Data carried with nv_req |
| shdn_n_pin | input | 1 | Active-low shutdown pin |
| wiper0 | output | 7 | Channel 0 wiper code |
| wiper1 | output | 7 | Channel 1 wiper code |
| off0 | output | 1 | Channel 0 shutdown flag |
| off1 | output | 1 | Channel 1 shutdown flag |

## Verification
A write strobe and a high busy flag can arrive in the same cycle. The bench provokes this by raising busy together with writes to a channel, to a general-purpose byte and to the control register. It judges the result by the missing request in the next cycle and by read-backs that still show the old values. A stored-value write makes the image update, the wiper mirror and the request happen in the same cycle. Each of the three is checked separately after that write, through the read port, the wiper output and the request line.

// File: rtl/dual_wiper_regs.sv
module dual_wiper_regs #(
  parameter int WIPER_W = 7,
  parameter int DATA_W  = 8,
  parameter int ADDR_W  = 4,
  parameter int GP_N    = 5,
  parameter logic [WIPER_W-1:0] WIPER_MID = 7'h40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              nv_busy,
  output logic              nv_req,
  output logic [ADDR_W-1:0] nv_addr,
  output logic [DATA_W-1:0] nv_data,
  input  logic              shdn_n_pin,
  output logic [WIPER_W-1:0] wiper0,
  output logic [WIPER_W-1:0] wiper1,
  output logic              off0,
  output logic              off1
);
  localparam int GP_BASE  = 2;
  localparam int CTL_ADDR = GP_BASE + GP_N + 1;
  localparam int SEL_BIT  = DATA_W - 1;
  localparam int SD_BIT   = DATA_W - 2;
  localparam int BUSY_BIT = DATA_W - 3;
  localparam int PAD_W    = DATA_W - WIPER_W;

  logic [WIPER_W-1:0] wiper [2];
  logic [WIPER_W-1:0] image [2];
  logic [DATA_W-1:0]  gp [GP_N];
  logic               acr_vol, acr_sd;

  wire wr_ok  = wr_en && !nv_busy;
  wire is_ch  = addr < ADDR_W'(2);
  wire is_ctl = addr == ADDR_W'(CTL_ADDR);
  wire [WIPER_W-1:0] wval = wdata[WIPER_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < 2; c++) begin
        wiper[c] <= WIPER_MID;
        image[c] <= WIPER_MID;
      end
      for (int g = 0; g < GP_N; g++) gp[g] <= '0;
      acr_vol <= 1'b0;
      acr_sd  <= 1'b1;
      nv_req  <= 1'b0;
      nv_addr <= '0;
      nv_data <= '0;
    end else begin
      nv_req <= 1'b0;
      if (wr_ok) begin
        if (is_ch) begin
          wiper[addr[0]] <= wval;
          if (!acr_vol) begin
            image[addr[0]] <= wval;
            nv_req  <= 1'b1;
            nv_addr <= addr;
            nv_data <= {{PAD_W{1'b0}}, wval};
          end
        end
        for (int g = 0; g < GP_N; g++)
          if (addr == ADDR_W'(GP_BASE + g)) begin
            gp[g]   <= wdata;
            nv_req  <= 1'b1;
            nv_addr <= addr;
            nv_data <= wdata;
          end
        if (is_ctl) begin
          acr_vol <= wdata[SEL_BIT];
          acr_sd  <= wdata[SD_BIT];
        end
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (is_ch)
      rdata = {{PAD_W{1'b0}}, acr_vol ? wiper[addr[0]] : image[addr[0]]};
    for (int g = 0; g < GP_N; g++)
      if (addr == ADDR_W'(GP_BASE + g)) rdata = gp[g];
    if (is_ctl) begin
      rdata[SEL_BIT]  = acr_vol;
      rdata[SD_BIT]   = acr_sd;
      rdata[BUSY_BIT] = nv_busy;
    end
  end

  assign wiper0 = wiper[0];
  assign wiper1 = wiper[1];
  assign off0   = !acr_sd || !shdn_n_pin;
  assign off1   = !acr_sd || !shdn_n_pin;
endmodule

module dual_wiper_regs_chk #(
  parameter int WIPER_W = 7,
  parameter int DATA_W  = 8,
  parameter int ADDR_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] rdata,
  input logic              nv_busy,
  input logic              nv_req,
  input logic              shdn_n_pin,
  input logic [WIPER_W-1:0] wiper0,
  input logic [WIPER_W-1:0] wiper1,
  input logic              off0,
  input logic              off1,
  input logic              acr_vol
);
  p_busy_lock_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && nv_busy) |=> ($stable(wiper0) && $stable(wiper1) && !nv_req));

  p_mirror_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !nv_busy && addr == '0 && !acr_vol)
      |=> (nv_req && wiper0 == $past(wdata[WIPER_W-1:0])));

  p_req_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
    nv_req |-> $past(wr_en && !nv_busy));

  p_ch_msb_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (addr < ADDR_W'(2)) |-> !rdata[DATA_W-1]);

  p_pin_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !shdn_n_pin |-> (off0 && off1));

  p_keep_wiper_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (off0 && !wr_en) |=> $stable(wiper0));
endmodule

bind dual_wiper_regs dual_wiper_regs_chk #(
  .WIPER_W(WIPER_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) i_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .rdata(rdata), .nv_busy(nv_busy), .nv_req(nv_req),
  .shdn_n_pin(shdn_n_pin), .wiper0(wiper0), .wiper1(wiper1),
  .off0(off0), .off1(off1), .acr_vol(acr_vol)
);

// File: tb/test_dual_wiper_regs.sv
module test_dual_wiper_regs;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       nv_busy = 1'b0;
  logic       nv_req;
  logic [3:0] nv_addr;
  logic [7:0] nv_data;
  logic       shdn_n_pin = 1'b1;
  logic [6:0] wiper0, wiper1;
  logic       off0, off1;

  int n_chk = 0;
  int n_bad = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  dual_wiper_regs i_dual_wiper_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .nv_busy(nv_busy), .nv_req(nv_req), .nv_addr(nv_addr),
    .nv_data(nv_data), .shdn_n_pin(shdn_n_pin), .wiper0(wiper0),
    .wiper1(wiper1), .off0(off0), .off1(off1)
  );

  task automatic check(input int req, input string what, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // kind: 0 write (exp = request), 1 read, 2 wiper0, 3 wiper1, 4 {off1,off0}, 5 set pin
  localparam int NV = 42;
  localparam logic [27:0] VEC [NV] = '{
    {4'd1, 3'd1, 4'h8, 8'h00, 1'b0, 8'h40},  // R1 control reset
    {4'd1, 3'd1, 4'h0, 8'h00, 1'b0, 8'h40},  // R1 image reset
    {4'd3, 3'd0, 4'h0, 8'h77, 1'b0, 8'h01},  // R3 image write requests
    {4'd3, 3'd1, 4'h0, 8'h00, 1'b0, 8'h77},  // R3 image read
    {4'd3, 3'd2, 4'h0, 8'h00, 1'b0, 8'h77},  // R3 mirror to wiper
    {4'd10,3'd0, 4'h1, 8'hFF, 1'b0, 8'h01},  // R10 msb dropped
    {4'd10,3'd1, 4'h1, 8'h00, 1'b0, 8'h7F},  // R10
    {4'd10,3'd3, 4'h0, 8'h00, 1'b0, 8'h7F},  // R10 top code
    {4'd7, 3'd0, 4'h8, 8'hFF, 1'b0, 8'h00},  // R7 no request
    {4'd7, 3'd1, 4'h8, 8'h00, 1'b0, 8'hC0},  // R7 only 7,6 stick
    {4'd4, 3'd0, 4'h0, 8'h12, 1'b0, 8'h00},  // R4 live write no request
    {4'd4, 3'd2, 4'h0, 8'h00, 1'b0, 8'h12},  // R4
    {4'd4, 3'd1, 4'h0, 8'h00, 1'b0, 8'h12},  // R4 read live
    {4'd4, 3'd0, 4'h8, 8'h40, 1'b0, 8'h00},  // R4 back to image
    {4'd4, 3'd1, 4'h0, 8'h00, 1'b0, 8'h77},  // R4 image untouched
    {4'd4, 3'd2, 4'h0, 8'h00, 1'b0, 8'h12},  // R4 read leaves wiper
    {4'd5, 3'd0, 4'h3, 8'hA5, 1'b0, 8'h01},  // R5
    {4'd5, 3'd1, 4'h3, 8'h00, 1'b0, 8'hA5},  // R5
    {4'd2, 3'd1, 4'h6, 8'h00, 1'b0, 8'h00},  // R2 last gp
    {4'd2, 3'd0, 4'h7, 8'h55, 1'b0, 8'h00},  // R2 reserved
    {4'd2, 3'd1, 4'h7, 8'h00, 1'b0, 8'h00},  // R2
    {4'd2, 3'd0, 4'h9, 8'h55, 1'b0, 8'h00},  // R2 out of map
    {4'd2, 3'd1, 4'h9, 8'h00, 1'b0, 8'h00},  // R2
    {4'd6, 3'd0, 4'h0, 8'h33, 1'b1, 8'h00},  // R6 busy channel
    {4'd6, 3'd2, 4'h0, 8'h00, 1'b0, 8'h12},  // R6
    {4'd6, 3'd1, 4'h0, 8'h00, 1'b0, 8'h77},  // R6
    {4'd6, 3'd0, 4'h8, 8'h80, 1'b1, 8'h00},  // R6 busy control
    {4'd7, 3'd1, 4'h8, 8'h00, 1'b1, 8'h60},  // R7 busy bit
    {4'd6, 3'd0, 4'h5, 8'h11, 1'b1, 8'h00},  // R6 busy gp
    {4'd6, 3'd1, 4'h5, 8'h00, 1'b0, 8'h00},  // R6
    {4'd8, 3'd4, 4'h0, 8'h00, 1'b0, 8'h00},  // R8 both off clear
    {4'd8, 3'd0, 4'h8, 8'h00, 1'b0, 8'h00},  // R8 bit shutdown
    {4'd8, 3'd4, 4'h0, 8'h00, 1'b0, 8'h03},  // R8
    {4'd9, 3'd2, 4'h0, 8'h00, 1'b0, 8'h12},  // R9 held
    {4'd9, 3'd0, 4'h0, 8'h05, 1'b0, 8'h01},  // R9 writable in shutdown
    {4'd9, 3'd2, 4'h0, 8'h00, 1'b0, 8'h05},  // R9
    {4'd9, 3'd0, 4'h8, 8'h40, 1'b0, 8'h00},  // R9 leave shutdown
    {4'd9, 3'd4, 4'h0, 8'h00, 1'b0, 8'h00},  // R9
    {4'd9, 3'd2, 4'h0, 8'h00, 1'b0, 8'h05},  // R9 resumes
    {4'd8, 3'd5, 4'h0, 8'h00, 1'b0, 8'h00},  // R8 pin low
    {4'd8, 3'd4, 4'h0, 8'h00, 1'b0, 8'h03},  // R8
    {4'd8, 3'd5, 4'h0, 8'h01, 1'b0, 8'h00}   // R8 pin high
  };

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state at the ports
    check(1, "wiper0 reset", {1'b0, wiper0}, 8'h40);
    check(1, "wiper1 reset", {1'b0, wiper1}, 8'h40);
    check(1, "request reset", {7'd0, nv_req}, 8'h00);
    check(1, "off reset", {6'd0, off1, off0}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      logic [3:0] rq; logic [2:0] kd; logic [3:0] ad; logic [7:0] dt; logic bz; logic [7:0] ex;
      {rq, kd, ad, dt, bz, ex} = VEC[i];
      @(negedge clk);
      case (kd)
        3'd0: begin
          wr_en = 1'b1; addr = ad; wdata = dt; nv_busy = bz;
          @(negedge clk);
          check(int'(rq), "write request", {7'd0, nv_req}, ex);
          wr_en = 1'b0; nv_busy = 1'b0;
        end
        3'd1: begin
          addr = ad; nv_busy = bz; #1;
          check(int'(rq), "read", rdata, ex);
          nv_busy = 1'b0;
        end
        3'd2: check(int'(rq), "wiper0", {1'b0, wiper0}, ex);
        3'd3: check(int'(rq), "wiper1", {1'b0, wiper1}, ex);
        3'd4: check(int'(rq), "off flags", {6'd0, off1, off0}, ex);
        default: begin shdn_n_pin = dt[0]; #1; end
      endcase
    end

    // R5 request carries address and byte, then drops
    @(negedge clk);
    wr_en = 1'b1; addr = 4'h4; wdata = 8'h3C;
    @(negedge clk);
    wr_en = 1'b0;
    check(5, "request addr", {4'd0, nv_addr}, 8'h04);
    check(5, "request data", nv_data, 8'h3C);
    @(negedge clk);
    check(3, "request one cycle", {7'd0, nv_req}, 8'h00);

    // R1 reset in mid-run restores defaults
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    addr = 4'h8; #1;
    check(1, "control after reset", rdata, 8'h40);
    addr = 4'h4; #1;
    check(1, "gp after reset", rdata, 8'h00);
    check(1, "wiper0 after reset", {1'b0, wiper0}, 8'h40);
    finish_run();
  end
endmodule